// File: doc/BRIEF.md
# Background Subtraction Unit

This unit turns a stream of 16-bit colour pixels into a one-bit foreground mask by comparing each pixel with a stored reference image. The reference is kept in an external linear memory that holds two images back to back. The first image region, starting at address 0, holds a captured background. The second region starts right after the last background word and holds the previous frame.

In static mode the unit compares against the captured background. A capture pulse arms it, and the next frame that begins with a start-of-frame flag is written into the background region. The mask stays black until that frame has been fully written. In dynamic mode each pixel is compared against the same position of the previous frame. The current pixel is written over that position in the same cycle as the read, so the region always holds the last frame. A still scene gives an all-black mask.

A pixel is marked as foreground when its colour distance exceeds an 8-bit threshold. The threshold is taken from a set of switches at the moment a single push key is pressed. The key is debounced.

Top module: `bgsub_unit`

## Requirements
- R1: Pixels use the layout red = bits 15:11, green = bits 10:5, blue = bits 4:0. The colour distance is 2·|Δred| + |Δgreen| + 2·|Δblue|, which ranges from 0 to 187.
- R2: A pixel is foreground (mask_out = 1) only when the distance is strictly greater than the threshold. A distance equal to the threshold gives 0. The threshold is 32 after reset.
- R3: A pixel accepted with pix_valid produces mask_valid exactly two cycles later, in order. mask_out is 0 whenever mask_valid is 0, and both are 0 after reset.
- R4: In static mode the memory address for a pixel at frame index i is i, which is the background region. Dynamic operation never writes that region.
- R5: In dynamic mode the pixel at index i reads address FRAME_PIXELS + i and writes itself to the same address in the same cycle. The memory returns the content from before the write, and that old content is the reference.
- R6: After a capture pulse, the next static-mode frame that starts with pix_sof is written into addresses 0..FRAME_PIXELS-1. Until its last pixel is written, every static-mode mask bit is 0, including those of a frame sent before any capture.
- R7: The threshold is loaded from thr_sw only on a debounced rising edge of thr_key. A high pulse shorter than DEBOUNCE_CYCLES cycles leaves the threshold unchanged.
- R8: pix_sof sets the frame index to 0 for that pixel. The index then advances by one per accepted pixel and wraps from FRAME_PIXELS-1 to 0.
- R9: In dynamic mode, a frame identical to the previous frame gives a mask of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dyn | input | 1 | 0 = compare with captured background, 1 = compare with previous frame |
| capture | input | 1 | One-cycle pulse that arms a background capture |
| pix_valid | input | 1 | Pixel present on pix_data |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | 16 | Colour pixel, 5-6-5 layout |
| thr_sw | input | 8 | Threshold setting switches |
| thr_key | input | 1 | Raw key that loads the threshold |
| mem_addr | output | ADDR_W | Word address shared by read and write |
| mem_rd_en | output | 1 | Read request; data returns on the next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd_en |
| mask_valid | output | 1 | mask_out carries a result |
| mask_out | output | 1 | 1 = foreground, 0 = background |

## Verification
The assertions check several properties on every cycle:
- the two-cycle output latency and the rule that mask_out is 0 when not valid;
- that static traffic stays in the background region and dynamic traffic stays in the previous-frame region;
- that every dynamic write comes with a read of the same address;
- that no foreground bit is produced in static mode before a capture has completed;
- that the threshold never changes without an earlier key level.

Some behaviours can only be shown by the bench's scenarios:
- the distance arithmetic at the equality boundary;
- the rejection of short key pulses;
- the contents written into each region;
- the read-old-data reference in dynamic mode;
- the all-black mask for a repeated frame.

// File: rtl/bgsub_unit.sv
module bgsub_unit #(
  parameter int          FRAME_PIXELS    = 76800,
  parameter int          DEBOUNCE_CYCLES = 250000,
  parameter logic [7:0]  THR_RESET       = 8'd32,
  parameter int          ADDR_W          = $clog2(2 * FRAME_PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dyn,
  input  logic              capture,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic [15:0]       pix_data,
  input  logic [7:0]        thr_sw,
  input  logic              thr_key,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              mask_valid,
  output logic              mask_out
);
  localparam int IDX_W = $clog2(FRAME_PIXELS);
  localparam int DCW   = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_PIXELS - 1);
  localparam logic [DCW-1:0]   DLIM = DCW'(DEBOUNCE_CYCLES - 1);

  logic [IDX_W-1:0] cnt, idx;
  logic cap_arm, capturing, bg_ok, cap_wr;
  logic v1, g1;
  logic [15:0] p1;
  logic [4:0] dr, db;
  logic [5:0] dg;
  logic [7:0] score, thr;
  logic ks1, ks2, kdb;
  logic [DCW-1:0] dcnt;

  assign idx       = pix_sof ? '0 : cnt;
  assign cap_wr    = pix_valid && !mode_dyn && (capturing || (cap_arm && pix_sof));
  assign mem_addr  = mode_dyn ? ADDR_W'(FRAME_PIXELS) + ADDR_W'(idx) : ADDR_W'(idx);
  assign mem_rd_en = pix_valid && !cap_wr;
  assign mem_wr_en = (pix_valid && mode_dyn) || cap_wr;
  assign mem_wdata = pix_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      cap_arm   <= 1'b0;
      capturing <= 1'b0;
      bg_ok     <= 1'b0;
    end else begin
      if (pix_valid) cnt <= (idx == LAST) ? '0 : idx + 1'b1;
      if (capture) begin
        cap_arm   <= 1'b1;
        capturing <= 1'b0;
        bg_ok     <= 1'b0;
      end else if (cap_wr) begin
        cap_arm <= 1'b0;
        if (idx == LAST) begin
          capturing <= 1'b0;
          bg_ok     <= 1'b1;
        end else begin
          capturing <= 1'b1;
        end
      end
    end
  end

  assign dr = (p1[15:11] >= mem_rdata[15:11]) ? p1[15:11] - mem_rdata[15:11]
                                               : mem_rdata[15:11] - p1[15:11];
  assign dg = (p1[10:5] >= mem_rdata[10:5]) ? p1[10:5] - mem_rdata[10:5]
                                             : mem_rdata[10:5] - p1[10:5];
  assign db = (p1[4:0] >= mem_rdata[4:0]) ? p1[4:0] - mem_rdata[4:0]
                                           : mem_rdata[4:0] - p1[4:0];
  assign score = {2'b00, dr, 1'b0} + {2'b00, dg} + {2'b00, db, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      g1         <= 1'b0;
      p1         <= '0;
      mask_valid <= 1'b0;
      mask_out   <= 1'b0;
    end else begin
      v1 <= pix_valid;
      if (pix_valid) begin
        p1 <= pix_data;
        g1 <= mode_dyn || bg_ok;
      end
      mask_valid <= v1;
      mask_out   <= v1 && g1 && (score > thr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ks1  <= 1'b0;
      ks2  <= 1'b0;
      kdb  <= 1'b0;
      dcnt <= '0;
      thr  <= THR_RESET;
    end else begin
      ks1 <= thr_key;
      ks2 <= ks1;
      if (ks2 == kdb) begin
        dcnt <= '0;
      end else if (dcnt == DLIM) begin
        dcnt <= '0;
        kdb  <= ks2;
        if (ks2) thr <= thr_sw;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bgsub_unit_chk.sv
module bgsub_unit_chk #(
  parameter int FRAME_PIXELS = 76800,
  parameter int ADDR_W       = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              mode_dyn,
  input logic              thr_key,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              mask_valid,
  input logic              mask_out,
  input logic [7:0]        thr,
  input logic              bg_ok
);
  localparam logic [ADDR_W:0] NREG = (ADDR_W + 1)'(FRAME_PIXELS);

  AST_MASK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> $past(pix_valid, 2)); // R3
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_out |-> mask_valid); // R3
  AST_STATIC_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_en || mem_wr_en) && !mode_dyn) |-> ({1'b0, mem_addr} < NREG)); // R4
  AST_DYN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_en || mem_wr_en) && mode_dyn) |-> ({1'b0, mem_addr} >= NREG)); // R5
  AST_DYN_READ_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mode_dyn) |-> mem_rd_en); // R5
  AST_NO_FG_BEFORE_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_out && !$past(mode_dyn, 2)) |-> $past(bg_ok, 2)); // R6
  AST_THR_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != $past(thr)) |-> $past(thr_key, 3)); // R7
endmodule

bind bgsub_unit bgsub_unit_chk #(.FRAME_PIXELS(FRAME_PIXELS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .mode_dyn(mode_dyn),
  .thr_key(thr_key), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mask_valid(mask_valid), .mask_out(mask_out),
  .thr(thr), .bg_ok(bg_ok)
);

// File: tb/bgsub_unit_test.sv
module bgsub_unit_test;
  localparam int N   = 8;
  localparam int DEB = 4;
  localparam int AW  = $clog2(2 * N);
  localparam logic [16:0] TBL [8] = '{
    {16'h8410, 1'b0}, {16'hFC10, 1'b0}, {16'h0410, 1'b0}, {16'h0430, 1'b1},
    {16'h8010, 1'b0}, {16'h87FF, 1'b1}, {16'h0000, 1'b1}, {16'hFFFF, 1'b1}
  };

  logic clk = 0, rst_n = 0, mode_dyn = 0, capture = 0;
  logic pix_valid = 0, pix_sof = 0, thr_key = 0;
  logic [15:0] pix_data = '0, mem_wdata, mem_rdata = '0;
  logic [7:0] thr_sw = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd_en, mem_wr_en, mask_valid, mask_out;
  logic [15:0] mem [2*N];
  bit eq [64];
  string tq [64];
  int wp = 0, rp = 0, checks = 0, fails = 0, bidx = 0, thr_b = 32;
  bit done = 0;

  bgsub_unit #(.FRAME_PIXELS(N), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .mode_dyn(mode_dyn), .capture(capture),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_data(pix_data),
    .thr_sw(thr_sw), .thr_key(thr_key), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mask_valid(mask_valid), .mask_out(mask_out)
  );

  always #4 clk = ~clk;

  initial for (int i = 0; i < 2 * N; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fg(input logic [15:0] a, input logic [15:0] b, input int t);
    int d;
    d = 2 * ((a[15:11] > b[15:11]) ? a[15:11] - b[15:11] : b[15:11] - a[15:11])
      + ((a[10:5] > b[10:5]) ? a[10:5] - b[10:5] : b[10:5] - a[10:5])
      + 2 * ((a[4:0] > b[4:0]) ? a[4:0] - b[4:0] : b[4:0] - a[4:0]);
    return d > t;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mask_valid) begin
      if (rp == wp) chk(0, "R3 unexpected mask_valid", 1, 0);
      else begin
        chk(mask_out == eq[rp % 64], tq[rp % 64], mask_out, eq[rp % 64]);
        rp++;
      end
    end else if (rst_n) begin
      chk(mask_out == 1'b0, "R3 mask_out low when not valid", mask_out, 0);
    end
  end

  task automatic send(input logic [15:0] d, input bit sof, input bit e, input string r);
    int ea;
    bit ex;
    @(negedge clk);
    if (sof) bidx = 0;
    ex = mode_dyn ? fg(d, mem[N + bidx], thr_b) : e;
    pix_valid = 1; pix_sof = sof; pix_data = d;
    eq[wp % 64] = ex; tq[wp % 64] = r; wp++;
    ea = mode_dyn ? N + bidx : bidx;
    #1;
    chk(int'(mem_addr) == ea, "R8 R4 frame index address", mem_addr, ea);
    if (mode_dyn) chk(mem_rd_en && mem_wr_en, "R5 read and write together", {mem_rd_en, mem_wr_en}, 3);
    bidx = (bidx + 1) % N;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0; pix_sof = 0;
    end
  endtask

  task automatic press(input logic [7:0] v, input int hold);
    @(negedge clk);
    thr_sw = v; thr_key = 1;
    idle(hold);
    thr_key = 0;
    idle(14);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(2);
    chk(!mask_valid && !mask_out && !mem_rd_en && !mem_wr_en, "R3 reset state",
        {mask_valid, mask_out, mem_rd_en, mem_wr_en}, 0);

    for (int i = 0; i < N; i++) send(16'hFFFF, i == 0, 1'b0, "R6 masked before any capture");
    @(negedge clk); pix_valid = 0; capture = 1;
    @(negedge clk); capture = 0;
    for (int i = 0; i < N; i++) send(16'h8410, i == 0, 1'b0, "R6 masked during capture frame");
    idle(3);
    for (int i = 0; i < N; i++) chk(mem[i] == 16'h8410, "R6 background written", mem[i], 16'h8410);
    chk(mem[N] == 16'h0000, "R4 previous-frame region untouched by capture", mem[N], 0);

    for (int i = 0; i < N; i++) send(TBL[i][16:1], i == 0, TBL[i][0], "R1 R2 distance table");
    idle(3);

    press(8'd100, 3);
    send(16'h0000, 1, 1'b1, "R7 short key pulse ignored");
    for (int i = 1; i < N; i++) send(16'h8410, 0, 1'b0, "R2 equal pixel");
    idle(3);

    press(8'd100, 10); thr_b = 100;
    send(16'h0000, 1, 1'b0, "R7 threshold 100 loaded");
    send(16'hFFFF, 0, 1'b0, "R7 threshold 100 loaded");
    for (int i = 2; i < N; i++) send(16'h8410, 0, 1'b0, "R2 equal pixel");
    idle(3);

    press(8'd90, 10); thr_b = 90;
    send(16'h0000, 1, 1'b1, "R7 threshold 90 loaded");
    send(16'hFFFF, 0, 1'b1, "R2 distance 91 above 90");
    send(16'h87FF, 0, 1'b0, "R2 distance 61 below 90");
    send(16'h0430, 0, 1'b0, "R2 distance 33 below 90");
    for (int i = 4; i < N; i++) send(16'h8410, 0, 1'b0, "R2 equal pixel");
    idle(3);

    mode_dyn = 1;
    for (int i = 0; i < N; i++) send(16'h8410, i == 0, 1'b0, "R5 reference is old content");
    for (int i = 0; i < N; i++) send(16'h8410, i == 0, 1'b0, "R9 still scene all black");
    for (int i = 0; i < N; i++) send((i == 3) ? 16'hFFFF : 16'h8410, i == 0, 1'b0, "R5 R9 moved pixel");
    idle(3);
    chk(mem[N + 3] == 16'hFFFF, "R5 current pixel written back", mem[N + 3], 16'hFFFF);
    chk(mem[3] == 16'h8410, "R4 background untouched in dynamic mode", mem[3], 16'h8410);

    for (int i = 0; i < 3; i++) send(16'h8410, i == 0, 1'b0, "R8 partial frame");
    send(16'h8410, 1, 1'b0, "R8 restart at start of frame");
    for (int i = 1; i < N; i++) send(16'h8410, 0, 1'b0, "R8 frame body");
    send(16'h8410, 0, 1'b0, "R8 wrap to index 0");
    idle(6);
    chk(rp == wp, "R3 every pixel produced a result", rp, wp);
    finish_run();
  end
endmodule